// File: doc/BRIEF.md
# Network Controller Command and Interrupt Register Unit

This unit is the 16-bit register front end of a network controller. Software writes and reads it over a plain word-wide register bus with a one-cycle write strobe and a combinational read path. It holds the command register, two data configuration registers, an end-of-buffer count register, and the interrupt mask and interrupt status registers. Command writes become one-cycle launch pulses to the transmit, receive, timer, resource-read and address-filter-load engines. Those engines answer with per-bit completion strobes and with event strobes that set status bits. A level interrupt is raised whenever an enabled status bit is set.

A small two-state machine tracks the reset mode. `MODE_RESET` is entered on hardware reset (transition `HW_RESET`) and on any command write that carries the software-reset bit (transition `SW_RESET`). `MODE_RUN` is entered from `MODE_RESET` by a command write without that bit (transition `LEAVE_RESET`). Otherwise the state holds (transition `HOLD`). The configuration registers can be changed only in `MODE_RESET`. The software-reset bit of the command register reads as 1 exactly while the machine is in `MODE_RESET`.

Top module: `nic_cmd_irq_unit`

## Requirements
- R1: After hardware reset the command register reads 0x0094 (software reset bit 7, timer stop bit 4 and receiver disable bit 2 set). The end-of-buffer count reads 0x02F8. Mask, status and both configuration registers read 0, `irq` is 0 and `op_go` is 0.
- R2: A command write (address 0) ORs the written bits that fall in mask 0x03BF into the register. The bit meanings are 0 halt transmit, 1 transmit, 2 receiver disable, 3 receiver enable, 4 timer stop, 5 timer start, 7 software reset, 8 read resource and 9 load address filter. Bits 6 and 10 to 15 always read 0.
- R3: A written receiver enable (bit 3) clears receiver disable (bit 2), and a written receiver disable clears receiver enable unless enable is written in the same word. A written timer start (bit 5) clears timer stop (bit 4), and a written stop clears start unless start is written too. Bits 4 and 5 are never both set.
- R4: A command write carrying bit 7 clears bits 0, 1, 8 and 9, sets bits 2 and 7, and puts the unit in reset mode.
- R5: In reset mode, a command write without bit 7 leaves reset mode, so bit 7 reads 0 afterwards.
- R6: In the cycle after a command write, `op_go` is high for exactly one cycle on each bit that the write requested and that is set in the new register value. Bit 7 pulses whenever it is written.
- R7: `op_done[i]` clears command bit i one cycle later. `op_done[7]` has no effect.
- R8: `irq` is high exactly when the bitwise AND of mask (address 3) and status (address 4) is nonzero. Mask writes drop bit 15.
- R9: Status bits clear when written with 1. Only the bits in 0x1EE0 exist (5 resource exhausted, 6 descriptors exhausted, 7 timer underflow, 9 transmit done, 10 packet received, 11 programmable, 12 filter load done), and `evt[i]` sets them. An event wins over a clear of the same bit in the same cycle.
- R10: Clearing status bit 5 while it is set also sets command bit 8 and pulses `op_go[8]` in the next cycle.
- R11: Configuration register 1 (address 1, mask 0xBFFF) and configuration register 2 (address 2, mask 0xF017) take writes only in reset mode. Writes outside reset mode leave them unchanged.
- R12: The end-of-buffer count (address 5) takes any write at any time. Reads of addresses 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| reg_wr | input | 1 | Write strobe, one word per cycle |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data |
| op_go | output | 10 | One-cycle launch pulses, one per command bit |
| op_done | input | 10 | Completion strobes, one per command bit |
| evt | input | 16 | Event strobes that set status bits |
| irq | output | 1 | Level interrupt |
| in_reset | output | 1 | High while the unit is in reset mode |
| cfg1 | output | 16 | Configuration register 1 |
| cfg2 | output | 16 | Configuration register 2 |
| eob_count | output | 16 | End-of-buffer count |

## Verification
The hardest situation to reach from the ports is the interplay inside a single command word: cancelling pairs, a software reset mixed with other operations, and the exit from reset mode all act on the same write. The bench therefore sweeps all 1024 values of the ten low command bits twice. One sweep starts from the hardware-reset state and one from run mode. Each result is compared against a bench model built from the requirement text. Status behaviour is swept over all 128 combinations of event bits with a varying clear pattern. Event and clear of the same bit are also driven into the same cycle.

// File: rtl/nic_cmd_pkg.sv
package nic_cmd_pkg;
    localparam int REG_W = 16;
    localparam int CMD_W = 10;

    localparam int CB_HALT_TX  = 0;
    localparam int CB_TX_GO    = 1;
    localparam int CB_RX_OFF   = 2;
    localparam int CB_RX_ON    = 3;
    localparam int CB_TMR_STOP = 4;
    localparam int CB_TMR_RUN  = 5;
    localparam int CB_SRST     = 7;
    localparam int CB_RES_RD   = 8;
    localparam int CB_FLT_LD   = 9;

    localparam logic [REG_W-1:0] CMD_KEEP  = 16'h03BF;
    localparam logic [REG_W-1:0] ST_IMPL   = 16'h1EE0;
    localparam int               ST_RES_EMPTY = 5;
    localparam logic [REG_W-1:0] CFG1_KEEP = 16'hBFFF;
    localparam logic [REG_W-1:0] CFG2_KEEP = 16'hF017;
    localparam logic [REG_W-1:0] MASK_KEEP = 16'h7FFF;
    localparam logic [REG_W-1:0] EOB_INIT  = 16'h02F8;

    localparam int A_CMD   = 0;
    localparam int A_CFG1  = 1;
    localparam int A_CFG2  = 2;
    localparam int A_IMASK = 3;
    localparam int A_ISTAT = 4;
    localparam int A_EOB   = 5;

    typedef enum logic {
        MODE_RESET = 1'b0,
        MODE_RUN   = 1'b1
    } mode_e;
endpackage

// File: rtl/nic_mode_fsm.sv
module nic_mode_fsm
    import nic_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic cmd_srst,
    output logic in_reset
);
    mode_e state_q, state_d;

    // Next state: SW_RESET, LEAVE_RESET or HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_RESET: if (cmd_wr && !cmd_srst) state_d = MODE_RUN;
            MODE_RUN:   if (cmd_wr && cmd_srst)  state_d = MODE_RESET;
            default:    state_d = MODE_RESET;
        endcase
    end

    // State register; HW_RESET enters MODE_RESET
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_RESET;
        else        state_q <= state_d;
    end

    // Output process
    always_comb begin
        unique case (state_q)
            MODE_RESET: in_reset = 1'b1;
            MODE_RUN:   in_reset = 1'b0;
            default:    in_reset = 1'b1;
        endcase
    end

    p_leave_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_RESET && cmd_wr && !cmd_srst) |=> (state_q == MODE_RUN));
    p_enter_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_srst) |=> (state_q == MODE_RESET));
endmodule

// File: rtl/nic_cmd_bits.sv
module nic_cmd_bits
    import nic_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             res_rd_req,
    input  logic [CMD_W-1:0] done_i,
    output logic [CMD_W-1:0] cmd_q,
    output logic [CMD_W-1:0] go_q
);
    localparam logic [CMD_W-1:0] KEEP    = CMD_KEEP[CMD_W-1:0];
    localparam logic [CMD_W-1:0] SRST_B  = CMD_W'(1) << CB_SRST;
    localparam logic [CMD_W-1:0] RST_CLR = (CMD_W'(1) << CB_HALT_TX) | (CMD_W'(1) << CB_TX_GO)
                                         | (CMD_W'(1) << CB_RES_RD)  | (CMD_W'(1) << CB_FLT_LD);
    localparam logic [CMD_W-1:0] INIT    = (CMD_W'(1) << CB_TMR_STOP) | (CMD_W'(1) << CB_RX_OFF);

    logic [CMD_W-1:0] req, nxt;

    always_comb begin
        nxt = cmd_q & ~done_i;
        req = '0;
        if (cmd_wr) begin
            req = wdata[CMD_W-1:0] & KEEP;
            nxt = nxt | req;
            if (req[CB_RX_OFF] && !req[CB_RX_ON])    nxt[CB_RX_ON]   = 1'b0;
            if (req[CB_RX_ON])                       nxt[CB_RX_OFF]  = 1'b0;
            if (req[CB_TMR_STOP] && !req[CB_TMR_RUN]) nxt[CB_TMR_RUN] = 1'b0;
            if (req[CB_TMR_RUN])                     nxt[CB_TMR_STOP] = 1'b0;
            if (req[CB_SRST]) begin
                nxt = nxt & ~RST_CLR;
                nxt[CB_RX_OFF] = 1'b1;
            end
        end
        if (res_rd_req) begin
            req[CB_RES_RD] = 1'b1;
            nxt[CB_RES_RD] = 1'b1;
        end
        nxt[CB_SRST] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= INIT;
            go_q  <= '0;
        end else begin
            cmd_q <= nxt;
            go_q  <= req & (nxt | SRST_B);
        end
    end

    p_go_has_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((go_q & ~SRST_B & ~cmd_q) == '0));
    p_timer_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_q[CB_TMR_STOP] && cmd_q[CB_TMR_RUN]));
    p_done_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i[CB_TX_GO] && !cmd_wr) |=> !cmd_q[CB_TX_GO]);
endmodule

// File: rtl/nic_irq_regs.sv
module nic_irq_regs
    import nic_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_wr,
    input  logic             stat_wr,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] evt_i,
    output logic [REG_W-1:0] mask_q,
    output logic [REG_W-1:0] stat_q,
    output logic             irq_o,
    output logic             res_rd_req
);
    logic [REG_W-1:0] clr, evt_m;

    assign clr        = stat_wr ? (wdata & stat_q) : '0;
    assign evt_m      = evt_i & ST_IMPL;
    assign res_rd_req = clr[ST_RES_EMPTY];
    assign irq_o      = |(mask_q & stat_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            stat_q <= '0;
        end else begin
            if (mask_wr) mask_q <= wdata & MASK_KEEP;
            stat_q <= (stat_q & ~clr) | evt_m;
        end
    end

    p_evt_raises_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (((evt_m & mask_q) != '0) && !mask_wr) |=> irq_o);
    p_evt_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_m != '0) |=> ((stat_q & $past(evt_m)) == $past(evt_m)));
endmodule

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs
    import nic_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_reset,
    input  logic             cfg1_wr,
    input  logic             cfg2_wr,
    input  logic             eob_wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] cfg1_q,
    output logic [REG_W-1:0] cfg2_q,
    output logic [REG_W-1:0] eob_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg1_q <= '0;
            cfg2_q <= '0;
            eob_q  <= EOB_INIT;
        end else begin
            if (cfg1_wr && in_reset) cfg1_q <= wdata & CFG1_KEEP;
            if (cfg2_wr && in_reset) cfg2_q <= wdata & CFG2_KEEP;
            if (eob_wr)              eob_q  <= wdata;
        end
    end

    p_cfg_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_reset |=> ($stable(cfg1_q) && $stable(cfg2_q)));
endmodule

// File: rtl/nic_cmd_irq_unit.sv
module nic_cmd_irq_unit
    import nic_cmd_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [CMD_W-1:0]  op_go,
    input  logic [CMD_W-1:0]  op_done,
    input  logic [REG_W-1:0]  evt,
    output logic              irq,
    output logic              in_reset,
    output logic [REG_W-1:0]  cfg1,
    output logic [REG_W-1:0]  cfg2,
    output logic [REG_W-1:0]  eob_count
);
    localparam int NREG = 6;

    logic [NREG-1:0]  sel;
    logic [CMD_W-1:0] cmd_bits;
    logic [REG_W-1:0] mask_v, stat_v, cmd_full;
    logic             res_rd_req;

    for (genvar g = 0; g < NREG; g++) begin : g_dec
        assign sel[g] = reg_wr && (reg_addr == ADDR_W'(g));
    end

    nic_mode_fsm u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (sel[A_CMD]),
        .cmd_srst (reg_wdata[CB_SRST]),
        .in_reset (in_reset)
    );

    nic_cmd_bits u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (sel[A_CMD]),
        .wdata      (reg_wdata),
        .res_rd_req (res_rd_req),
        .done_i     (op_done),
        .cmd_q      (cmd_bits),
        .go_q       (op_go)
    );

    nic_irq_regs u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_wr    (sel[A_IMASK]),
        .stat_wr    (sel[A_ISTAT]),
        .wdata      (reg_wdata),
        .evt_i      (evt),
        .mask_q     (mask_v),
        .stat_q     (stat_v),
        .irq_o      (irq),
        .res_rd_req (res_rd_req)
    );

    nic_cfg_regs u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_reset (in_reset),
        .cfg1_wr  (sel[A_CFG1]),
        .cfg2_wr  (sel[A_CFG2]),
        .eob_wr   (sel[A_EOB]),
        .wdata    (reg_wdata),
        .cfg1_q   (cfg1),
        .cfg2_q   (cfg2),
        .eob_q    (eob_count)
    );

    always_comb begin
        cmd_full          = {{(REG_W-CMD_W){1'b0}}, cmd_bits};
        cmd_full[CB_SRST] = in_reset;
    end

    always_comb begin
        case (reg_addr)
            ADDR_W'(A_CMD):   reg_rdata = cmd_full;
            ADDR_W'(A_CFG1):  reg_rdata = cfg1;
            ADDR_W'(A_CFG2):  reg_rdata = cfg2;
            ADDR_W'(A_IMASK): reg_rdata = mask_v;
            ADDR_W'(A_ISTAT): reg_rdata = stat_v;
            ADDR_W'(A_EOB):   reg_rdata = eob_count;
            default:          reg_rdata = '0;
        endcase
    end

    p_rdres_follows_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_rd_req |=> (op_go[CB_RES_RD] && cmd_bits[CB_RES_RD]));
endmodule

// File: tb/nic_cmd_irq_unit_tb.sv
module nic_cmd_irq_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [9:0]  op_go;
    logic [9:0]  op_done = '0;
    logic [15:0] evt = '0;
    logic        irq, in_reset;
    logic [15:0] cfg1, cfg2, eob_count;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    nic_cmd_irq_unit #(.ADDR_W(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .op_go(op_go),
        .op_done(op_done), .evt(evt), .irq(irq), .in_reset(in_reset),
        .cfg1(cfg1), .cfg2(cfg2), .eob_count(eob_count)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic hw_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a; #0.5; d = reg_rdata;
    endtask

    function automatic logic [15:0] exp_cmd(input logic [15:0] cur, input logic [15:0] v);
        logic [15:0] n;
        n = cur;
        if (cur[7] && !v[7]) n[7] = 1'b0;
        n = n | (v & 16'h03BF);
        if (v[2] && !v[3]) n[3] = 1'b0;
        if (v[3]) n[2] = 1'b0;
        if (v[4] && !v[5]) n[5] = 1'b0;
        if (v[5]) n[4] = 1'b0;
        if (v[7]) begin
            n = n & ~16'h0303;
            n = n | 16'h0084;
        end
        return n;
    endfunction

    function automatic logic [15:0] spread(input logic [6:0] e);
        logic [15:0] s;
        s = '0;
        for (int k = 0; k < 7; k++) s[(k < 3) ? 5 + k : 6 + k] = e[k];
        return s;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] d, n, s, c;
        hw_reset();
        // R1 reset state
        rd(3'd0, d); chk("R1 cmd", d, 16'h0094);
        rd(3'd1, d); chk("R1 cfg1", d, 16'h0000);
        rd(3'd2, d); chk("R1 cfg2", d, 16'h0000);
        rd(3'd3, d); chk("R1 mask", d, 16'h0000);
        rd(3'd4, d); chk("R1 status", d, 16'h0000);
        rd(3'd5, d); chk("R1 eob", d, 16'h02F8);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 go", {6'd0, op_go}, 16'd0);

        // R11 config writes in reset mode
        wr(3'd1, 16'hFFFF); rd(3'd1, d); chk("R11 cfg1 mask", d, 16'hBFFF);
        wr(3'd2, 16'hFFFF); rd(3'd2, d); chk("R11 cfg2 mask", d, 16'hF017);
        // R5 leave reset
        wr(3'd0, 16'h0000); rd(3'd0, d); chk("R5 leave reset", d, 16'h0014);
        chk("R5 in_reset", {15'd0, in_reset}, 16'd0);
        wr(3'd1, 16'h0000); rd(3'd1, d); chk("R11 cfg1 locked", d, 16'hBFFF);
        wr(3'd2, 16'h0000); rd(3'd2, d); chk("R11 cfg2 locked", d, 16'hF017);
        // R12 eob and unmapped
        wr(3'd5, 16'h1234); rd(3'd5, d); chk("R12 eob", d, 16'h1234);
        wr(3'd6, 16'hFFFF); rd(3'd6, d); chk("R12 unmapped 6", d, 16'h0000);
        wr(3'd7, 16'hFFFF); rd(3'd7, d); chk("R12 unmapped 7", d, 16'h0000);

        // R2 R3 R4 R6 sweep from reset state and from run mode
        for (int st = 0; st < 2; st++) begin
            for (int v = 0; v < 1024; v++) begin
                logic [15:0] w, cur;
                w = 16'(v) | ((v % 3 == 0) ? 16'hFC40 : 16'h0000);
                hw_reset();
                cur = 16'h0094;
                if (st == 1) begin
                    wr(3'd0, 16'h0000);
                    cur = 16'h0014;
                end
                n = exp_cmd(cur, w);
                wr(3'd0, w);
                chk("R6 go pulse", {6'd0, op_go}, w & 16'h03BF & n);
                rd(3'd0, d); chk("R2 R3 R4 cmd value", d, n);
                @(negedge clk);
                chk("R6 go one cycle", {6'd0, op_go}, 16'd0);
            end
        end

        // R7 completion clears, bit 7 ignored
        hw_reset();
        op_done = 10'h080; @(posedge clk); @(negedge clk); op_done = '0;
        rd(3'd0, d); chk("R7 done ignores reset bit", d, 16'h0094);
        wr(3'd0, 16'h0302);
        op_done = 10'h002; @(posedge clk); @(negedge clk); op_done = '0;
        rd(3'd0, d); chk("R7 done clears tx", d, 16'h0314);
        op_done = 10'h300; @(posedge clk); @(negedge clk); op_done = '0;
        rd(3'd0, d); chk("R7 done clears two", d, 16'h0014);

        // R8 R9 R10 status sweep
        for (int e = 0; e < 128; e++) begin
            logic rbe_clr;
            hw_reset();
            wr(3'd0, 16'h0000);
            s = spread(7'(e));
            evt = 16'hFFFF & (s | 16'h811F);
            @(posedge clk); @(negedge clk); evt = '0;
            rd(3'd4, d); chk("R9 event set", d, s);
            chk("R8 irq masked off", {15'd0, irq}, 16'd0);
            c = spread(7'(e) ^ 7'h2A) | 16'h8001;
            rbe_clr = s[5] & c[5];
            wr(3'd4, c);
            chk("R10 go res read", {6'd0, op_go}, rbe_clr ? 16'h0100 : 16'h0000);
            rd(3'd0, d); chk("R10 cmd res read", d, rbe_clr ? 16'h0114 : 16'h0014);
            rd(3'd4, d); chk("R9 w1c", d, s & ~c);
            wr(3'd3, 16'hFFFF);
            rd(3'd3, d); chk("R8 mask drops bit 15", d, 16'h7FFF);
            chk("R8 irq level", {15'd0, irq}, {15'd0, (s & ~c) != 16'd0});
        end

        // R9 event wins over simultaneous clear
        hw_reset();
        evt = 16'h0400; @(posedge clk); @(negedge clk);
        wr(3'd4, 16'h0400); evt = '0;
        rd(3'd4, d); chk("R9 event beats clear", d, 16'h0400);
        wr(3'd3, 16'h0400);
        chk("R8 irq on", {15'd0, irq}, 16'd1);
        wr(3'd4, 16'h0400);
        chk("R8 irq off after clear", {15'd0, irq}, 16'd0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule